// File: doc/BRIEF.md
# Dual-Channel PWM Action Qualifier

This block turns the state of an external time base into two PWM waveforms, A and B. It receives the counter value, the counting direction, one-cycle strobes marking the zero and period points, and a tick enable that marks time-base steps. Each channel has its own 16-bit compare value and its own action register. The action register gives a 2-bit action for each event: counter zero, counter period, and a match of the channel's own compare value while counting up. On every tick the registered output is driven low, driven high, toggled, or held, depending on which event occurred.

A software force register can hold either output at a fixed level for as long as software keeps it there. The register is shadowed. A separate reload field chooses when a newly written force value becomes active: at the next zero tick, at the next period tick, at whichever of those two comes first, or at the very next tick. Compare values are also shadowed and take effect at counter zero. All configuration goes through a plain write port: address, data and a write enable.

Top module: `pwmaq_top`

## Requirements
- R1: Reset drives both outputs low and clears every compare value, action field and force field. Until something is written, ticks leave both outputs low.
- R2: Write addresses: 0 is the force register, 1 is action A, 2 is action B, 4 is compare A, 5 is compare B. A compare write goes to a shadow copy. The shadow is copied to the active compare on a tick with the zero strobe set, and the tick that copies uses the old active value.
- R3: Action codes are 00 hold, 01 drive low, 10 drive high and 11 toggle. The output register changes on the tick edge.
- R4: In an action register, bits [1:0] hold the zero action and bits [3:2] hold the period action. The compare action is at bits [5:4] for channel A and bits [9:8] for channel B. All other bits have no effect on that channel.
- R5: A compare event occurs only on a tick where the counter is counting up and equals the channel's active compare value. No compare event occurs while counting down.
- R6: When events coincide, the channel uses the code of the highest-priority event present, even if that code is hold. The order is compare, then period, then zero.
- R7: When tick is low, neither output changes, whatever the strobes, counter or writes do.
- R8: In the force register, bits [1:0] control output A and bits [3:2] control output B. Code 01 forces low, 10 forces high, and 00 or 11 leave the event actions in charge. An active force overrides every event action.
- R9: Bits [7:6] of the force register select when the shadow force value is reloaded: 00 on a zero tick, 01 on a period tick, 10 on either of those, 11 on every tick. The reloaded value already governs the tick that reloads it.
- R10: An active force value persists across periods until a later reload replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base step enable |
| count | input | CNT_W | Time-base counter value |
| count_up | input | 1 | High while the counter is counting up |
| at_zero | input | 1 | Counter is at zero on this step |
| at_period | input | 1 | Counter is at the period value on this step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| pwm_out | output | NUM_CH | PWM outputs; bit 0 is A, bit 1 is B |

## Verification
The bench first drives an up-counting time base with normal polarity on A and inverted polarity on B. This shows that each output rises and falls at the expected counts and that B is the mirror image of A. A down-counting pass keeps the same settings, which separates compare events from the zero and period events. Toggle-only settings, a compare value of zero, a compare value equal to the period, and a zero-length period, where zero and period coincide, make the priority order visible at the outputs. Force words are then written under each of the four reload modes, along with action words that set only the other channel's compare bits and a gapped tick pattern. These runs separate when a force takes hold, which field bits a channel ignores, and whether the outputs move only on ticks.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_code_e;

   typedef enum logic [1:0] {
      RLD_ZERO   = 2'b00,
      RLD_PERIOD = 2'b01,
      RLD_EITHER = 2'b10,
      RLD_NOW    = 2'b11
   } rld_mode_e;

   typedef struct packed {
      logic [1:0] cmp;
      logic [1:0] prd;
      logic [1:0] zro;
   } act_fields_t;

   localparam int ADDR_FORCE    = 0;
   localparam int ADDR_ACT_BASE = 1;
   localparam int ADDR_CMP_BASE = 4;
   localparam int MIN_ADDR_W    = 3;

   // next output level for a plain action code
   function automatic logic apply_action(input logic cur, input logic [1:0] code);
      case (act_code_e'(code))
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         ACT_TOGGLE: return ~cur;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/pwmaq_regs.sv
module pwmaq_regs
   import pwmaq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3,
   parameter int NUM_CH = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic                         at_zero,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [CNT_W-1:0]             wr_data,
   output logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
   output act_fields_t [NUM_CH-1:0]     act_fld,
   output logic [2*NUM_CH-1:0]          frc_shd,
   output logic [1:0]                   frc_mode
);

   localparam int FRC_W = 2 * NUM_CH;

   logic frc_hit;
   assign frc_hit = wr_en && (wr_addr == ADDR_W'(ADDR_FORCE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frc_shd  <= '0;
         frc_mode <= '0;
      end else if (frc_hit) begin
         frc_shd  <= wr_data[FRC_W-1:0];
         frc_mode <= wr_data[7:6];
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int ACT_IDX = ADDR_ACT_BASE + c;
      localparam int CMP_IDX = ADDR_CMP_BASE + c;
      localparam int CMP_LSB = 4 + 4 * c;

      logic [CNT_W-1:0] shd_q;
      logic [CNT_W-1:0] act_q;
      act_fields_t      fld_q;
      logic             act_hit;
      logic             cmp_hit;

      assign act_hit = wr_en && (wr_addr == ADDR_W'(ACT_IDX));
      assign cmp_hit = wr_en && (wr_addr == ADDR_W'(CMP_IDX));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q <= '0;
            act_q <= '0;
            fld_q <= '0;
         end else begin
            if (tick && at_zero) act_q <= shd_q;
            if (cmp_hit) shd_q <= wr_data;
            if (act_hit) begin
               fld_q.cmp <= wr_data[CMP_LSB +: 2];
               fld_q.prd <= wr_data[3:2];
               fld_q.zro <= wr_data[1:0];
            end
         end
      end

      assign cmp_act[c] = act_q;
      assign act_fld[c] = fld_q;
   end

endmodule

// File: rtl/pwmaq_force_sel.sv
module pwmaq_force_sel
   import pwmaq_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                at_zero,
   input  logic                at_period,
   input  logic [1:0]          frc_mode,
   input  logic [2*NUM_CH-1:0] frc_shd,
   output logic [2*NUM_CH-1:0] frc_eff,
   output logic [2*NUM_CH-1:0] frc_act
);

   logic due;
   logic reload_now;

   always_comb begin
      case (rld_mode_e'(frc_mode))
         RLD_ZERO:   due = at_zero;
         RLD_PERIOD: due = at_period;
         RLD_EITHER: due = at_zero | at_period;
         default:    due = 1'b1;
      endcase
   end

   assign reload_now = tick && due;
   assign frc_eff    = reload_now ? frc_shd : frc_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          frc_act <= '0;
      else if (reload_now) frc_act <= frc_shd;
   end

endmodule

// File: rtl/pwmaq_chan.sv
module pwmaq_chan
   import pwmaq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic             count_up,
   input  logic             at_zero,
   input  logic             at_period,
   input  logic [CNT_W-1:0] cmp_val,
   input  act_fields_t      fld,
   input  logic [1:0]       frc_code,
   output logic             pwm
);

   logic       cmp_evt;
   logic [1:0] sel_code;
   logic       nxt;

   assign cmp_evt = count_up && (count == cmp_val);

   always_comb begin
      if (cmp_evt)        sel_code = fld.cmp;
      else if (at_period) sel_code = fld.prd;
      else if (at_zero)   sel_code = fld.zro;
      else                sel_code = ACT_HOLD;
   end

   always_comb begin
      case (act_code_e'(frc_code))
         ACT_LOW:  nxt = 1'b0;
         ACT_HIGH: nxt = 1'b1;
         default:  nxt = apply_action(pwm, sel_code);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pwm <= 1'b0;
      else if (tick) pwm <= nxt;
   end

endmodule

// File: rtl/pwmaq_top.sv
module pwmaq_top
   import pwmaq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3,
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CNT_W-1:0]  count,
   input  logic              count_up,
   input  logic              at_zero,
   input  logic              at_period,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int FRC_W = 2 * NUM_CH;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("pwmaq_top: NUM_CH must be 1 to 3");
   end
   if (CNT_W < 4 * NUM_CH + 2) begin : g_bad_w
      $error("pwmaq_top: CNT_W too narrow for the action fields");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_a
      $error("pwmaq_top: ADDR_W too narrow for the register map");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
   act_fields_t [NUM_CH-1:0]     act_fld;
   logic [FRC_W-1:0]             frc_shd;
   logic [1:0]                   frc_mode;
   logic [FRC_W-1:0]             frc_eff;
   logic [FRC_W-1:0]             frc_act;

   pwmaq_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .at_zero  (at_zero),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cmp_act  (cmp_act),
      .act_fld  (act_fld),
      .frc_shd  (frc_shd),
      .frc_mode (frc_mode)
   );

   pwmaq_force_sel #(.NUM_CH(NUM_CH)) u_frc (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .at_zero   (at_zero),
      .at_period (at_period),
      .frc_mode  (frc_mode),
      .frc_shd   (frc_shd),
      .frc_eff   (frc_eff),
      .frc_act   (frc_act)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pwmaq_chan #(.CNT_W(CNT_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .count     (count),
         .count_up  (count_up),
         .at_zero   (at_zero),
         .at_period (at_period),
         .cmp_val   (cmp_act[c]),
         .fld       (act_fld[c]),
         .frc_code  (frc_eff[2*c +: 2]),
         .pwm       (pwm_out[c])
      );
   end

endmodule

// File: rtl/pwmaq_chk.sv
module pwmaq_chk #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         tick,
   input logic                         at_zero,
   input logic [NUM_CH-1:0]            pwm_out,
   input logic [1:0]                   frc_mode,
   input logic [2*NUM_CH-1:0]          frc_shd,
   input logic [2*NUM_CH-1:0]          frc_act,
   input logic [NUM_CH-1:0][CNT_W-1:0] cmp_act
);

   AST_STILL_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(pwm_out)); // R7

   AST_CMP_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmp_act) |-> $past(tick && at_zero)); // R2

   AST_FORCE_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frc_act) |-> $past(tick)); // R10

   AST_NOW_FORCE_LOW_A: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && frc_mode == 2'b11 && frc_shd[1:0] == 2'b01) |=> !pwm_out[0]); // R9

   AST_NOW_FORCE_HIGH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && frc_mode == 2'b11 && frc_shd[2*NUM_CH-1 -: 2] == 2'b10)
      |=> pwm_out[NUM_CH-1]); // R8

endmodule

bind pwmaq_top pwmaq_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .at_zero  (at_zero),
   .pwm_out  (pwm_out),
   .frc_mode (frc_mode),
   .frc_shd  (frc_shd),
   .frc_act  (frc_act),
   .cmp_act  (cmp_act)
);

// File: tb/tb_pwmaq_top.sv
module tb_pwmaq_top;

   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] count = '0;
   logic        count_up = 1'b0;
   logic        at_zero = 1'b0;
   logic        at_period = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  pwm_out;

   pwmaq_top dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .count_up(count_up),
      .at_zero(at_zero), .at_period(at_period), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_out(pwm_out)
   );

   always #(CLK_PER/2) clk = ~clk;

   typedef struct {
      logic [1:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference state built from the requirements
   logic [15:0] m_cmp_sh [2];
   logic [15:0] m_cmp_act[2];
   logic [1:0]  m_zc[2], m_pc[2], m_cc[2];
   logic [3:0]  m_fshd, m_fact;
   logic [1:0]  m_fmode;
   logic [1:0]  m_out;
   int          tb_cnt = 0;

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_cmp_sh[c] = '0; m_cmp_act[c] = '0; m_zc[c] = '0; m_pc[c] = '0; m_cc[c] = '0;
      end
      m_fshd = '0; m_fact = '0; m_fmode = '0; m_out = '0;
   endtask

   function automatic logic act(input logic cur, input logic [1:0] code);
      if (code == 2'b01) return 1'b0;
      if (code == 2'b10) return 1'b1;
      if (code == 2'b11) return ~cur;
      return cur;
   endfunction

   // driver: applies one cycle of stimulus and queues the expected outputs
   task automatic step(input bit tk, input logic [15:0] c, input bit up, input bit z,
                       input bit p, input bit we, input logic [2:0] a,
                       input logic [15:0] d, input string tag);
      bit due, rn;
      logic [3:0] eff;
      logic [1:0] nxt;
      sb_item_t it;
      @(negedge clk); #1;
      tick = tk; count = c; count_up = up; at_zero = z; at_period = p;
      wr_en = we; wr_addr = a; wr_data = d;
      case (m_fmode)
         2'b00: due = z;
         2'b01: due = p;
         2'b10: due = z | p;
         default: due = 1'b1;
      endcase
      rn = tk && due;
      eff = rn ? m_fshd : m_fact;
      for (int ch = 0; ch < 2; ch++) begin
         logic [1:0] fc, sel;
         fc = eff[2*ch +: 2];
         if (up && c == m_cmp_act[ch]) sel = m_cc[ch];
         else if (p)                   sel = m_pc[ch];
         else if (z)                   sel = m_zc[ch];
         else                          sel = 2'b00;
         if (fc == 2'b01)      nxt[ch] = 1'b0;
         else if (fc == 2'b10) nxt[ch] = 1'b1;
         else                  nxt[ch] = act(m_out[ch], sel);
      end
      if (tk) m_out = nxt;
      if (rn) m_fact = m_fshd;
      if (tk && z) begin
         m_cmp_act[0] = m_cmp_sh[0];
         m_cmp_act[1] = m_cmp_sh[1];
      end
      if (we) begin
         case (a)
            3'd0: begin m_fshd = d[3:0]; m_fmode = d[7:6]; end
            3'd1: begin m_zc[0] = d[1:0]; m_pc[0] = d[3:2]; m_cc[0] = d[5:4]; end
            3'd2: begin m_zc[1] = d[1:0]; m_pc[1] = d[3:2]; m_cc[1] = d[9:8]; end
            3'd4: m_cmp_sh[0] = d;
            3'd5: m_cmp_sh[1] = d;
            default: ;
         endcase
      end
      it.exp = m_out;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compares results one cycle after each queued item
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         checks++;
         if (pwm_out !== it.exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", it.tag, pwm_out, it.exp);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
      step(1'b0, count, count_up, 1'b0, 1'b0, 1'b1, a, d, tag);
   endtask

   task automatic run(input int n, input int per, input bit up, input bit gap,
                      input string tag);
      for (int i = 0; i < n; i++) begin
         bit tk;
         tk = gap ? (i % 2 == 0) : 1'b1;
         step(tk, 16'(tb_cnt), up, tb_cnt == 0, tb_cnt == per, 1'b0, 3'd0, 16'd0, tag);
         if (tk) begin
            if (up) tb_cnt = (tb_cnt >= per) ? 0 : tb_cnt + 1;
            else    tb_cnt = (tb_cnt == 0) ? per : tb_cnt - 1;
         end
      end
   endtask

   initial begin
      #(CLK_PER * 200000);
      if (!done) begin
         bad++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      checks++;
      if (pwm_out !== 2'b00) begin
         bad++;
         $display("FAIL R1 actual=%b expected=00", pwm_out);
      end
      rst_n = 1'b1;
      // R1: unconfigured block stays low
      run(14, 9, 1'b1, 1'b0, "R1");
      // R2/R3: normal polarity on A, inverted on B
      wr(3'd4, 16'd3, "R2");
      wr(3'd5, 16'd5, "R2");
      wr(3'd1, 16'h001A, "R3");
      wr(3'd2, 16'h0205, "R3");
      tb_cnt = 0;
      run(30, 9, 1'b1, 1'b0, "R3");
      // R2: new compare takes hold only from the next zero
      run(4, 9, 1'b1, 1'b0, "R2");
      wr(3'd4, 16'd7, "R2");
      run(20, 9, 1'b1, 1'b0, "R2");
      // R5: counting down, no compare events
      tb_cnt = 9;
      run(22, 9, 1'b0, 1'b0, "R5");
      // R3: toggle at zero only
      wr(3'd1, 16'h0003, "R3");
      tb_cnt = 0;
      run(25, 9, 1'b1, 1'b0, "R3");
      // R6: compare beats zero, compare beats period, period beats zero
      wr(3'd1, 16'h0036, "R6");
      wr(3'd4, 16'd0, "R6");
      tb_cnt = 0;
      run(22, 9, 1'b1, 1'b0, "R6");
      wr(3'd4, 16'd9, "R6");
      run(22, 9, 1'b1, 1'b0, "R6");
      tb_cnt = 0;
      run(6, 0, 1'b1, 1'b0, "R6");
      // R4: the other channel's compare field is ignored
      wr(3'd1, 16'h0300, "R4");
      wr(3'd2, 16'h0030, "R4");
      tb_cnt = 0;
      run(22, 9, 1'b1, 1'b0, "R4");
      // restore normal and inverted settings
      wr(3'd4, 16'd3, "R3");
      wr(3'd1, 16'h001A, "R3");
      wr(3'd2, 16'h0205, "R3");
      tb_cnt = 0;
      run(12, 9, 1'b1, 1'b0, "R3");
      // R9/R10: each reload mode
      tb_cnt = 4;
      wr(3'd0, 16'h0001, "R9");
      run(25, 9, 1'b1, 1'b0, "R10");
      wr(3'd0, 16'h0042, "R9");
      run(25, 9, 1'b1, 1'b0, "R9");
      wr(3'd0, 16'h0088, "R9");
      run(25, 9, 1'b1, 1'b0, "R9");
      wr(3'd0, 16'h00C5, "R9");
      run(12, 9, 1'b1, 1'b0, "R8");
      // R8: codes 11 and 00 release both outputs
      wr(3'd0, 16'h00C3, "R8");
      run(22, 9, 1'b1, 1'b0, "R8");
      // R7: gapped ticks with strobes held
      run(40, 9, 1'b1, 1'b1, "R7");
      step(1'b0, 16'd0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 16'd0, "R7");
      step(1'b0, 16'd3, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 16'h00C5, "R7");
      step(1'b0, 16'd3, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "R7");
      run(4, 9, 1'b1, 1'b0, "R8");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule